// File: doc/BRIEF.md
# Per-Slot Fetch-Block Branch Selector

This block sits in the fetch stage of a pipeline. It takes one fetch address per cycle. It works out the aligned block of instruction slots that holds that address. Every slot address in the block is looked up in parallel in two tables: a direct-mapped target cache and a table of two-bit direction counters. A slot counts as a branch only when the target cache hits for its address. That branch is predicted taken when its counter is in one of the two taken states. Slots that come before the fetch entry point take no part in selection. Not-taken branches do not stop fetch, so a block can carry several of them. The first predicted-taken branch supplies the next fetch address. When there is none, fetch moves on to the next sequential block. The lookup path is combinational from the fetch address to the outputs. Decode receives a valid mask and the per-slot branch and prediction flags, so it can tell how each branch in the block was implicitly predicted.

Each direction counter is a four-state machine. The states are `CTR_STRONG_NT` (0), `CTR_WEAK_NT` (1), `CTR_WEAK_T` (2) and `CTR_STRONG_T` (3). A taken outcome steps one state toward `CTR_STRONG_T`, and `CTR_STRONG_T` stays put. A not-taken outcome steps one state toward `CTR_STRONG_NT`, and `CTR_STRONG_NT` stays put. Reset puts every counter in `CTR_WEAK_NT`.

A single update port carries one resolved branch per cycle. On each clock edge it writes one target-cache entry and moves one direction counter.

Top module: `fbs_fetch_selector`

## Requirements
- R1: After reset every target-cache entry is invalid and every direction counter is 1 (weakly not-taken). Until the first update, every fetch is sequential and shows no branch.
- R2: With default parameters (4 slots of 4 bytes), the block base is `fetch_addr` with bits [3:0] cleared. Slot i is looked up at base + 4*i. The entry offset is `fetch_addr[3:2]`.
- R3: A slot hits when the target-cache entry at index addr[5:2] is valid and its stored tag equals addr[31:6]. A slot without a hit has `slot_is_branch` 0 and `slot_pred_taken` 0, whatever its counter holds.
- R4: A slot that is a branch has `slot_pred_taken` 1 exactly when its counter (indexed by addr[7:2]) is 2 or 3.
- R5: When a slot is selected, `next_fetch_addr` is that slot's stored target and `redirect` is 1. Otherwise `next_fetch_addr` is base + 16 and `redirect` is 0. Not-taken branches never stop fetch.
- R6: The selected slot is the lowest-numbered slot at or after the entry offset that is predicted taken. `slot_valid` is 1 from the entry offset up to and including the selected slot, or up to the last slot when none is selected. `slot_is_branch` and `slot_pred_taken` are 0 wherever `slot_valid` is 0.
- R7: Slots below the entry offset are never selected and show 0 on all three per-slot outputs, even when they hold predicted-taken branches.
- R8: An update moves counter `upd_addr[7:2]` one step up on a taken outcome, saturating at 3. It moves it one step down on a not-taken outcome, saturating at 0. The change is seen by lookups from the next cycle.
- R9: An update writes target-cache entry `upd_addr[5:2]` as valid with tag `upd_addr[31:6]` and target `upd_target`. The entry is seen by lookups from the next cycle.
- R10: The target cache is direct-mapped. An update whose index matches an entry with a different tag replaces that entry, and the old address then misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_addr | input | ADDR_W | Current fetch address; may point into the middle of a block |
| upd_valid | input | 1 | Update port carries a resolved branch this cycle |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_target | input | ADDR_W | Target to store for that branch |
| upd_taken | input | 1 | Resolved direction (1 = taken) |
| next_fetch_addr | output | ADDR_W | Address to fetch next |
| redirect | output | 1 | A predicted-taken branch was selected |
| slot_valid | output | SLOTS | Slots of the block that are part of this fetch |
| slot_is_branch | output | SLOTS | Valid slots that hit in the target cache |
| slot_pred_taken | output | SLOTS | Implicit per-slot prediction handed to decode |

## Verification
The bound checker watches the output relations on every cycle. It checks that at most one slot is predicted taken, that the entry slot is always valid, and that the head slot is valid only for entry offset 0. It checks that no branch flag appears outside the valid mask and that a fetch with no taken prediction goes sequential. It also checks two update effects seen through slot 0 while the fetch address is held: the counter steps one saturating move, and a just-written entry hits. Only the bench's scenarios can show the rest, by comparing against a behavioural model. That covers which slot wins when several are taken, masking of taken branches below the entry offset, eviction on a tag conflict, the hysteresis around the weak states, and the exact targets returned.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_T    = 2'd2,
        CTR_STRONG_T  = 2'd3
    } ctr_state_e;

    // Saturating step of a direction counter for one resolved outcome.
    function automatic ctr_state_e ctr_advance(input ctr_state_e cur, input logic taken);
        ctr_state_e nxt;
        unique case (cur)
            CTR_STRONG_NT: nxt = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   nxt = taken ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    nxt = taken ? CTR_STRONG_T : CTR_WEAK_NT;
            CTR_STRONG_T:  nxt = taken ? CTR_STRONG_T : CTR_WEAK_T;
            default:       nxt = CTR_WEAK_NT;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/fbs_dir_table.sv
module fbs_dir_table
    import fbs_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SLOTS   = 4,
    parameter int ENTRIES = 64,
    parameter int OFS_W   = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [SLOTS-1:0][ADDR_W-1:0]   rd_addr,
    output logic [SLOTS-1:0][1:0]          rd_ctr,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic                           wr_taken
);
    localparam int IDX_W = $clog2(ENTRIES);

    ctr_state_e             ctr_q [ENTRIES];
    ctr_state_e             wr_next;
    logic [IDX_W-1:0]       wr_idx;
    logic                   unused_addr_bits;

    assign wr_idx = wr_addr[OFS_W +: IDX_W];
    assign unused_addr_bits = ^{rd_addr, wr_addr};

    // Next-state logic of the counter being updated.
    always_comb begin
        wr_next = ctr_advance(ctr_q[wr_idx], wr_taken);
    end

    // State register array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                ctr_q[e] <= CTR_WEAK_NT;
            end
        end else if (wr_en) begin
            ctr_q[wr_idx] <= wr_next;
        end
    end

    // One read port per slot.
    for (genvar g = 0; g < SLOTS; g++) begin : g_rd
        assign rd_ctr[g] = ctr_q[rd_addr[g][OFS_W +: IDX_W]];
    end

endmodule

// File: rtl/fbs_target_cache.sv
module fbs_target_cache #(
    parameter int ADDR_W  = 32,
    parameter int SLOTS   = 4,
    parameter int ENTRIES = 16,
    parameter int OFS_W   = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [SLOTS-1:0][ADDR_W-1:0]   rd_addr,
    output logic [SLOTS-1:0]               rd_hit,
    output logic [SLOTS-1:0][ADDR_W-1:0]   rd_target,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [ADDR_W-1:0]              wr_target
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = ADDR_W - OFS_W - IDX_W;

    logic                   vld_q [ENTRIES];
    logic [TAG_W-1:0]       tag_q [ENTRIES];
    logic [ADDR_W-1:0]      tgt_q [ENTRIES];
    logic [IDX_W-1:0]       wr_idx;
    logic                   unused_addr_bits;

    assign wr_idx = wr_addr[OFS_W +: IDX_W];
    assign unused_addr_bits = ^{rd_addr, wr_addr};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                vld_q[e] <= 1'b0;
            end
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and target storage need no reset: the valid bits guard them.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_addr[ADDR_W-1 -: TAG_W];
            tgt_q[wr_idx] <= wr_target;
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_rd
        logic [IDX_W-1:0] idx;
        assign idx          = rd_addr[g][OFS_W +: IDX_W];
        assign rd_hit[g]    = vld_q[idx] && (tag_q[idx] == rd_addr[g][ADDR_W-1 -: TAG_W]);
        assign rd_target[g] = tgt_q[idx];
    end

endmodule

// File: rtl/fbs_slot_select.sv
module fbs_slot_select #(
    parameter int ADDR_W = 32,
    parameter int SLOTS  = 4
) (
    input  logic [$clog2(SLOTS)-1:0]       entry_ofs,
    input  logic [SLOTS-1:0]               hit,
    input  logic [SLOTS-1:0]               dir_taken,
    input  logic [SLOTS-1:0][ADDR_W-1:0]   target,
    input  logic [ADDR_W-1:0]              seq_addr,
    output logic [SLOTS-1:0]               slot_valid,
    output logic [SLOTS-1:0]               slot_is_branch,
    output logic [SLOTS-1:0]               slot_pred_taken,
    output logic [ADDR_W-1:0]              next_addr,
    output logic                           redirect
);
    logic taken_seen;

    // Priority walk from the lowest slot; the first taken branch ends the block.
    always_comb begin
        taken_seen      = 1'b0;
        next_addr       = seq_addr;
        slot_valid      = '0;
        slot_is_branch  = '0;
        slot_pred_taken = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if ((i >= int'(entry_ofs)) && !taken_seen) begin
                slot_valid[i] = 1'b1;
                if (hit[i]) begin
                    slot_is_branch[i] = 1'b1;
                    if (dir_taken[i]) begin
                        slot_pred_taken[i] = 1'b1;
                        taken_seen         = 1'b1;
                        next_addr          = target[i];
                    end
                end
            end
        end
        redirect = taken_seen;
    end

endmodule

// File: rtl/fbs_fetch_selector.sv
module fbs_fetch_selector #(
    parameter int ADDR_W      = 32,
    parameter int SLOTS       = 4,
    parameter int INSTR_BYTES = 4,
    parameter int TC_ENTRIES  = 16,
    parameter int DIR_ENTRIES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    fetch_addr,
    input  logic                 upd_valid,
    input  logic [ADDR_W-1:0]    upd_addr,
    input  logic [ADDR_W-1:0]    upd_target,
    input  logic                 upd_taken,
    output logic [ADDR_W-1:0]    next_fetch_addr,
    output logic                 redirect,
    output logic [SLOTS-1:0]     slot_valid,
    output logic [SLOTS-1:0]     slot_is_branch,
    output logic [SLOTS-1:0]     slot_pred_taken
);
    localparam int OFS_W       = $clog2(INSTR_BYTES);
    localparam int SLOT_W      = $clog2(SLOTS);
    localparam int BLK_W       = OFS_W + SLOT_W;
    localparam int BLOCK_BYTES = SLOTS * INSTR_BYTES;

    logic [ADDR_W-1:0]               block_base;
    logic [ADDR_W-1:0]               seq_addr;
    logic [SLOT_W-1:0]               entry_ofs;
    logic [SLOTS-1:0][ADDR_W-1:0]    slot_addr;
    logic [SLOTS-1:0]                tc_hit;
    logic [SLOTS-1:0][ADDR_W-1:0]    tc_target;
    logic [SLOTS-1:0][1:0]           slot_ctr;
    logic [SLOTS-1:0]                dir_taken;
    logic                            unused_fetch_bits;

    assign block_base        = {fetch_addr[ADDR_W-1:BLK_W], {BLK_W{1'b0}}};
    assign entry_ofs         = fetch_addr[OFS_W +: SLOT_W];
    assign seq_addr          = block_base + ADDR_W'(BLOCK_BYTES);
    assign unused_fetch_bits = ^fetch_addr[OFS_W-1:0];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign slot_addr[g] = block_base + ADDR_W'(g * INSTR_BYTES);
        assign dir_taken[g] = slot_ctr[g][1];
    end

    fbs_target_cache #(
        .ADDR_W  (ADDR_W),
        .SLOTS   (SLOTS),
        .ENTRIES (TC_ENTRIES),
        .OFS_W   (OFS_W)
    ) u_tcache (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr   (slot_addr),
        .rd_hit    (tc_hit),
        .rd_target (tc_target),
        .wr_en     (upd_valid),
        .wr_addr   (upd_addr),
        .wr_target (upd_target)
    );

    fbs_dir_table #(
        .ADDR_W  (ADDR_W),
        .SLOTS   (SLOTS),
        .ENTRIES (DIR_ENTRIES),
        .OFS_W   (OFS_W)
    ) u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (slot_addr),
        .rd_ctr   (slot_ctr),
        .wr_en    (upd_valid),
        .wr_addr  (upd_addr),
        .wr_taken (upd_taken)
    );

    fbs_slot_select #(
        .ADDR_W (ADDR_W),
        .SLOTS  (SLOTS)
    ) u_select (
        .entry_ofs       (entry_ofs),
        .hit             (tc_hit),
        .dir_taken       (dir_taken),
        .target          (tc_target),
        .seq_addr        (seq_addr),
        .slot_valid      (slot_valid),
        .slot_is_branch  (slot_is_branch),
        .slot_pred_taken (slot_pred_taken),
        .next_addr       (next_fetch_addr),
        .redirect        (redirect)
    );

endmodule

// File: rtl/fbs_fetch_selector_chk.sv
module fbs_fetch_selector_chk #(
    parameter int ADDR_W      = 32,
    parameter int SLOTS       = 4,
    parameter int INSTR_BYTES = 4,
    parameter int DIR_ENTRIES = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   fetch_addr,
    input logic                upd_valid,
    input logic [ADDR_W-1:0]   upd_addr,
    input logic                upd_taken,
    input logic [ADDR_W-1:0]   next_fetch_addr,
    input logic [SLOTS-1:0]    slot_valid,
    input logic [SLOTS-1:0]    slot_is_branch,
    input logic [SLOTS-1:0]    slot_pred_taken,
    input logic [1:0]          slot_ctr0
);
    localparam int OFS_W   = $clog2(INSTR_BYTES);
    localparam int SLOT_W  = $clog2(SLOTS);
    localparam int BLK_W   = OFS_W + SLOT_W;
    localparam int DIDX_W  = $clog2(DIR_ENTRIES);

    logic [ADDR_W-1:0] base;
    logic [SLOT_W-1:0] entry;
    logic              upd_on_head_ctr;
    logic              upd_on_head_slot;

    assign base  = {fetch_addr[ADDR_W-1:BLK_W], {BLK_W{1'b0}}};
    assign entry = fetch_addr[OFS_W +: SLOT_W];
    assign upd_on_head_ctr  = upd_valid && (upd_addr[OFS_W +: DIDX_W] == base[OFS_W +: DIDX_W]);
    assign upd_on_head_slot = upd_valid && (upd_addr[ADDR_W-1:OFS_W] == base[ADDR_W-1:OFS_W])
                              && (entry == '0);

    function automatic logic [1:0] sat_step(input logic [1:0] c, input logic t);
        if (t) return (c == 2'd3) ? 2'd3 : c + 2'd1;
        return (c == 2'd0) ? 2'd0 : c - 2'd1;
    endfunction

    // R5
    seq_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_pred_taken == '0) |-> (next_fetch_addr == base + ADDR_W'(SLOTS * INSTR_BYTES)));

    // R6
    one_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(slot_pred_taken) <= 1);

    // R6
    entry_slot_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid[entry] == 1'b1);

    // R7
    head_slot_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid[0] |-> (entry == '0));

    // R3
    branch_inside_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_is_branch | slot_pred_taken) & ~slot_valid) == '0);

    // R8
    ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_on_head_ctr |=> (!$stable(fetch_addr) || slot_ctr0 == sat_step($past(slot_ctr0), $past(upd_taken))));

    // R9
    hit_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_on_head_slot |=> (!$stable(fetch_addr) || slot_is_branch[0]));

endmodule

bind fbs_fetch_selector fbs_fetch_selector_chk #(
    .ADDR_W      (ADDR_W),
    .SLOTS       (SLOTS),
    .INSTR_BYTES (INSTR_BYTES),
    .DIR_ENTRIES (DIR_ENTRIES)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .fetch_addr      (fetch_addr),
    .upd_valid       (upd_valid),
    .upd_addr        (upd_addr),
    .upd_taken       (upd_taken),
    .next_fetch_addr (next_fetch_addr),
    .slot_valid      (slot_valid),
    .slot_is_branch  (slot_is_branch),
    .slot_pred_taken (slot_pred_taken),
    .slot_ctr0       (slot_ctr[0])
);

// File: tb/fbs_fetch_selector_tb.sv
module fbs_fetch_selector_tb;
    localparam int NS  = 4;
    localparam int TCN = 16;
    localparam int DRN = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_addr = '0;
    logic [31:0] upd_target = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] next_fetch_addr;
    logic        redirect;
    logic [NS-1:0] slot_valid, slot_is_branch, slot_pred_taken;

    always #2 clk = ~clk;

    fbs_fetch_selector u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr),
        .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_target(upd_target),
        .upd_taken(upd_taken), .next_fetch_addr(next_fetch_addr), .redirect(redirect),
        .slot_valid(slot_valid), .slot_is_branch(slot_is_branch),
        .slot_pred_taken(slot_pred_taken)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Behavioural reference: full word address stored per cache line.
    bit          m_vld [TCN];
    logic [31:0] m_word [TCN];
    logic [31:0] m_tgt [TCN];
    int          m_ctr [DRN];

    task automatic model_reset();
        for (int e = 0; e < TCN; e++) m_vld[e] = 0;
        for (int e = 0; e < DRN; e++) m_ctr[e] = 1;
    endtask

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual %h expected %h (fetch %h)", req, what, act, exp, fetch_addr);
        end
    endtask

    task automatic cycle(logic [31:0] fa, bit uv, logic [31:0] ua, logic [31:0] ut, bit uk, string req);
        logic [31:0] base, a, w, exp_next;
        logic [NS-1:0] ev, eb, ep;
        bit found;
        int entry;
        @(negedge clk);
        fetch_addr = fa; upd_valid = uv; upd_addr = ua; upd_target = ut; upd_taken = uk;
        #1;
        base = fa & ~32'hF;
        entry = int'((fa >> 2) & 32'h3);
        exp_next = base + 32'd16;
        ev = '0; eb = '0; ep = '0; found = 0;
        for (int i = 0; i < NS; i++) begin
            a = base + 32'(4 * i);
            w = a >> 2;
            if (i >= entry && !found) begin
                ev[i] = 1'b1;
                if (m_vld[w % TCN] && m_word[w % TCN] == w) begin
                    eb[i] = 1'b1;
                    if (m_ctr[w % DRN] >= 2) begin
                        ep[i] = 1'b1;
                        found = 1;
                        exp_next = m_tgt[w % TCN];
                    end
                end
            end
        end
        check(req, "next_fetch_addr", next_fetch_addr, exp_next);
        check(req, "redirect", 32'(redirect), 32'(found));
        check(req, "slot_valid", 32'(slot_valid), 32'(ev));
        check(req, "slot_is_branch", 32'(slot_is_branch), 32'(eb));
        check(req, "slot_pred_taken", 32'(slot_pred_taken), 32'(ep));
        @(posedge clk);
        if (uv) begin
            w = ua >> 2;
            m_vld[w % TCN] = 1;
            m_word[w % TCN] = w;
            m_tgt[w % TCN] = ut;
            if (uk) m_ctr[w % DRN] = (m_ctr[w % DRN] == 3) ? 3 : m_ctr[w % DRN] + 1;
            else    m_ctr[w % DRN] = (m_ctr[w % DRN] == 0) ? 0 : m_ctr[w % DRN] - 1;
        end
    endtask

    task automatic fetch(logic [31:0] fa, string req);
        cycle(fa, 0, 32'h0, 32'h0, 0, req);
    endtask

    task automatic upd(logic [31:0] ua, logic [31:0] ut, bit uk, string req);
        cycle(ua, 1, ua, ut, uk, req);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: empty tables, sequential fetch everywhere
        fetch(32'h0000_0104, "R1");
        fetch(32'h0000_0330, "R1");
        fetch(32'h0000_001C, "R1");

        // R9: new entry with counter moved to weakly taken
        upd(32'h0000_0100, 32'h0000_0800, 1, "R9");
        fetch(32'h0000_0100, "R9");
        fetch(32'h0000_0104, "R9");

        // R10: same cache index, other tag, evicts; R3: counter still taken but miss
        upd(32'h0000_0140, 32'h0000_0900, 0, "R10");
        fetch(32'h0000_0100, "R3");
        // R4: hit with counter 0 is a not-taken branch
        fetch(32'h0000_0140, "R4");

        // R5: two not-taken branches passed, taken branch in last slot
        upd(32'h0000_0200, 32'h0000_0A10, 0, "R5");
        upd(32'h0000_0204, 32'h0000_0A20, 0, "R5");
        upd(32'h0000_020C, 32'h0000_0A00, 1, "R5");
        fetch(32'h0000_0200, "R5");

        // R6: two taken branches, lowest wins and ends the block
        upd(32'h0000_0214, 32'h0000_0B00, 1, "R6");
        upd(32'h0000_021C, 32'h0000_0C00, 1, "R6");
        fetch(32'h0000_0210, "R6");
        // R7: entry past the first taken branch
        fetch(32'h0000_0218, "R7");
        fetch(32'h0000_0208, "R7");
        // R2: entry in last slot and mid-block lookups
        fetch(32'h0000_021C, "R2");
        fetch(32'h0000_0204, "R2");

        // R8: saturation and hysteresis on one counter
        for (int k = 0; k < 4; k++) upd(32'h0000_0220, 32'h0000_0D00, 1, "R8");
        fetch(32'h0000_0220, "R8");
        upd(32'h0000_0220, 32'h0000_0D00, 0, "R8");
        fetch(32'h0000_0220, "R8");
        for (int k = 0; k < 4; k++) upd(32'h0000_0220, 32'h0000_0D00, 0, "R8");
        fetch(32'h0000_0220, "R8");
        upd(32'h0000_0220, 32'h0000_0D00, 1, "R8");
        fetch(32'h0000_0220, "R8");

        // Mixed traffic against the model
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] fa, ua;
            fa = $urandom & 32'h0000_03FF;
            ua = $urandom & 32'h0000_03FC;
            if (($urandom % 8) == 0) fa = fa | 32'h0000_1000;
            if (($urandom % 8) == 0) ua = ua | 32'h0000_1000;
            cycle(fa, ($urandom % 3) == 0, ua, $urandom & 32'h0000_FFFC, $urandom % 2, "R6");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule